// File: doc/BRIEF.md
# Back-End Op Tagging Sampler

This block picks one micro-op out of the out-of-order back end at a programmable interval and follows that op until it retires. An interval counter runs either on clock cycles or on dispatched ops, chosen by a mode input. When the counter expires, a tag is armed and attached to a dispatched op, and the op's ID is recorded. The sampler then watches the completion and retirement strobes for that ID.

When the tagged op retires, the block captures a sample record and raises a one-cycle interrupt. The record holds the op ID, the cycles from tagging to retirement, the cycles from completion of the op's work to retirement, four branch flags and the branch target. The record stays frozen until software clears it. Only one op is followed at a time. A pipeline flush that happens before retirement drops the tag without an interrupt, and interval counting then starts over.

Top module: `op_tag_sampler`

## Requirements
- R1: With `cfg_by_ops`=0 the interval counter advances on every clock cycle, and with `cfg_by_ops`=1 it advances on every cycle with `disp_vld`=1. It counts only while `cfg_en`=1 and no tag is armed, tracked or held. It starts from zero each time counting resumes. It expires on the `cfg_interval`-th counted event, and a value of 0 acts as 1.
- R2: In op mode the tag goes to the first dispatch strictly after the dispatch that made the counter expire.
- R3: In cycle mode the tag goes to a dispatch in the expiry cycle if there is one. Otherwise it goes to the first dispatch in a later cycle.
- R4: `rec_tag_lat` equals the number of clock edges from the tagging dispatch to the retirement of the tagged op, so a retire on the edge after tagging gives 1.
- R5: `rec_cmpl_lat` equals the number of edges from the first completion strobe carrying the tagged ID to its retirement. It is 0 if no such completion was seen before the retire edge.
- R6: The record captures the retiring op's ID, the branch, taken, mispredicted and return flags, and the branch target, all from the retire strobe of the tagged op.
- R7: `irq` is high for exactly one cycle, in the first cycle after the retire edge. `rec_valid` rises in the same cycle.
- R8: While a tag is armed or tracked, or a record is held, further dispatches do not move the tag. While a record is held, the record does not change until `rec_clr`.
- R9: Completion and retire strobes that carry an ID other than the tagged one have no effect.
- R10: `flush` while a tag is armed or tracked drops it with no interrupt and no record. Interval counting then restarts from zero.
- R11: Both latency fields saturate at 2^`LAT_W`-1.
- R12: `rec_clr` while a record is held drops `rec_valid` on the next cycle, and a new interval then begins.
- R13: After reset `irq`=0 and `rec_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_en | input | 1 | Enables interval counting |
| cfg_by_ops | input | 1 | 0: count cycles, 1: count dispatched ops |
| cfg_interval | input | CNT_W | Interval length in counted events |
| disp_vld | input | 1 | An op is dispatched this cycle |
| disp_id | input | ID_W | ID of the dispatched op |
| cmpl_vld | input | 1 | An op finished its work this cycle |
| cmpl_id | input | ID_W | ID of the completing op |
| ret_vld | input | 1 | An op retires this cycle |
| ret_id | input | ID_W | ID of the retiring op |
| ret_branch | input | 1 | Retiring op is a branch |
| ret_taken | input | 1 | Retiring branch was taken |
| ret_mispred | input | 1 | Retiring branch was mispredicted |
| ret_return | input | 1 | Retiring op is a return |
| ret_target | input | ADDR_W | Branch target of the retiring op |
| flush | input | 1 | Back-end flush; drops an armed or tracked tag |
| rec_clr | input | 1 | Software clear of the held record |
| irq | output | 1 | One-cycle sample interrupt |
| rec_valid | output | 1 | Record is held and valid |
| rec_id | output | ID_W | ID of the sampled op |
| rec_tag_lat | output | LAT_W | Tag-to-retire cycles |
| rec_cmpl_lat | output | LAT_W | Completion-to-retire cycles |
| rec_branch | output | 1 | Sampled op was a branch |
| rec_taken | output | 1 | Sampled branch was taken |
| rec_mispred | output | 1 | Sampled branch was mispredicted |
| rec_return | output | 1 | Sampled op was a return |
| rec_target | output | ADDR_W | Branch target of the sampled op |

## Verification
The case that is hardest to reach from the ports is the one where the counter expires and the tag still has to wait for a later dispatch. It has to be shown separately for the two modes. The bench drives one sparse dispatch pattern, with gaps placed so that the cycle-mode expiry falls on an empty cycle, in both modes. Each mode must then pick a different op ID, and both IDs are known in advance. A flush between tag and retire, foreign-ID strobes during tracking, and a retire held back past the saturation point cover the remaining paths.

// File: rtl/ots_pkg.sv
package ots_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ARMED = 2'd1,
        S_TRACK = 2'd2,
        S_HOLD  = 2'd3
    } ots_state_e;

endpackage

// File: rtl/ots_interval.sv
module ots_interval #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             evt,
    input  logic [CNT_W-1:0] limit,
    output logic             expire
);
    localparam int EXT_W = CNT_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } regs_t;

    regs_t q, d;
    logic [EXT_W-1:0] nxt;
    logic             hit;

    always_comb begin
        d      = q;
        nxt    = {1'b0, q.cnt} + EXT_W'(1);
        hit    = (nxt >= {1'b0, limit});
        expire = run && evt && hit;
        if (!run) begin
            d.cnt = '0;
        end else if (evt) begin
            d.cnt = hit ? '0 : nxt[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/ots_satcnt.sv
module ots_satcnt #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         inc,
    output logic [W-1:0] value
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    typedef struct packed {
        logic [W-1:0] cnt;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d = q;
        if (start) begin
            d.cnt = W'(1);
        end else if (inc && (q.cnt != TOP)) begin
            d.cnt = q.cnt + W'(1);
        end
        value = q.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/op_tag_sampler.sv
module op_tag_sampler
    import ots_pkg::*;
#(
    parameter int ID_W   = 6,
    parameter int CNT_W  = 16,
    parameter int LAT_W  = 12,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic              cfg_by_ops,
    input  logic [CNT_W-1:0]  cfg_interval,
    input  logic              disp_vld,
    input  logic [ID_W-1:0]   disp_id,
    input  logic              cmpl_vld,
    input  logic [ID_W-1:0]   cmpl_id,
    input  logic              ret_vld,
    input  logic [ID_W-1:0]   ret_id,
    input  logic              ret_branch,
    input  logic              ret_taken,
    input  logic              ret_mispred,
    input  logic              ret_return,
    input  logic [ADDR_W-1:0] ret_target,
    input  logic              flush,
    input  logic              rec_clr,
    output logic              irq,
    output logic              rec_valid,
    output logic [ID_W-1:0]   rec_id,
    output logic [LAT_W-1:0]  rec_tag_lat,
    output logic [LAT_W-1:0]  rec_cmpl_lat,
    output logic              rec_branch,
    output logic              rec_taken,
    output logic              rec_mispred,
    output logic              rec_return,
    output logic [ADDR_W-1:0] rec_target
);
    localparam int NLAT = 2;
    localparam int L_TAG  = 0;
    localparam int L_CMPL = 1;

    typedef struct packed {
        ots_state_e        st;
        logic [ID_W-1:0]   tag;
        logic              done;
        logic              irq;
        logic [ID_W-1:0]   r_id;
        logic [LAT_W-1:0]  r_tlat;
        logic [LAT_W-1:0]  r_clat;
        logic              r_br;
        logic              r_tk;
        logic              r_mp;
        logic              r_rt;
        logic [ADDR_W-1:0] r_tgt;
    } regs_t;

    regs_t q, d;

    logic             expire;
    logic             ret_hit;
    logic             cmpl_hit;
    logic [NLAT-1:0]  lat_start;
    logic [NLAT-1:0]  lat_inc;
    logic [LAT_W-1:0] lat_val [NLAT];

    ots_interval #(.CNT_W(CNT_W)) u_interval (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (cfg_en && (q.st == S_IDLE)),
        .evt    (cfg_by_ops ? disp_vld : 1'b1),
        .limit  (cfg_interval),
        .expire (expire)
    );

    for (genvar g = 0; g < NLAT; g++) begin : g_lat
        ots_satcnt #(.W(LAT_W)) u_lat (
            .clk   (clk),
            .rst_n (rst_n),
            .start (lat_start[g]),
            .inc   (lat_inc[g]),
            .value (lat_val[g])
        );
    end

    always_comb begin
        d         = q;
        d.irq     = 1'b0;
        lat_start = '0;
        ret_hit   = ret_vld && (ret_id == q.tag);
        cmpl_hit  = cmpl_vld && (cmpl_id == q.tag);
        lat_inc[L_TAG]  = (q.st == S_TRACK);
        lat_inc[L_CMPL] = (q.st == S_TRACK) && q.done;

        case (q.st)
            S_IDLE: begin
                if (expire) begin
                    if (!cfg_by_ops && disp_vld) begin
                        d.st   = S_TRACK;
                        d.tag  = disp_id;
                        d.done = 1'b0;
                        lat_start[L_TAG] = 1'b1;
                    end else begin
                        d.st = S_ARMED;
                    end
                end
            end
            S_ARMED: begin
                if (flush) begin
                    d.st = S_IDLE;
                end else if (disp_vld) begin
                    d.st   = S_TRACK;
                    d.tag  = disp_id;
                    d.done = 1'b0;
                    lat_start[L_TAG] = 1'b1;
                end
            end
            S_TRACK: begin
                if (ret_hit) begin
                    d.st     = S_HOLD;
                    d.irq    = 1'b1;
                    d.r_id   = q.tag;
                    d.r_tlat = lat_val[L_TAG];
                    d.r_clat = q.done ? lat_val[L_CMPL] : '0;
                    d.r_br   = ret_branch;
                    d.r_tk   = ret_taken;
                    d.r_mp   = ret_mispred;
                    d.r_rt   = ret_return;
                    d.r_tgt  = ret_target;
                end else if (flush) begin
                    d.st = S_IDLE;
                end else if (cmpl_hit && !q.done) begin
                    d.done = 1'b1;
                    lat_start[L_CMPL] = 1'b1;
                end
            end
            S_HOLD: begin
                if (rec_clr) d.st = S_IDLE;
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign irq          = q.irq;
    assign rec_valid    = (q.st == S_HOLD);
    assign rec_id       = q.r_id;
    assign rec_tag_lat  = q.r_tlat;
    assign rec_cmpl_lat = q.r_clat;
    assign rec_branch   = q.r_br;
    assign rec_taken    = q.r_tk;
    assign rec_mispred  = q.r_mp;
    assign rec_return   = q.r_rt;
    assign rec_target   = q.r_tgt;
endmodule

// File: rtl/ots_checker.sv
module ots_checker #(
    parameter int ID_W  = 6,
    parameter int LAT_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rec_clr,
    input logic             irq,
    input logic             rec_valid,
    input logic [ID_W-1:0]  rec_id,
    input logic [LAT_W-1:0] rec_tag_lat,
    input logic [LAT_W-1:0] rec_cmpl_lat
);
    // R7
    irq_with_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> rec_valid);

    // R7
    record_rise_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rec_valid) |-> irq);

    // R7
    irq_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R8
    record_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && !rec_clr) |=> (rec_valid && $stable(rec_id)
            && $stable(rec_tag_lat) && $stable(rec_cmpl_lat)));

    // R4
    tag_lat_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |-> (rec_tag_lat != '0));

    // R5
    cmpl_within_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |-> (rec_cmpl_lat <= rec_tag_lat));
endmodule

bind op_tag_sampler ots_checker #(.ID_W(ID_W), .LAT_W(LAT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rec_clr      (rec_clr),
    .irq          (irq),
    .rec_valid    (rec_valid),
    .rec_id       (rec_id),
    .rec_tag_lat  (rec_tag_lat),
    .rec_cmpl_lat (rec_cmpl_lat)
);

// File: tb/op_tag_sampler_tb.sv
module op_tag_sampler_tb;
    localparam int ID_W = 6, CNT_W = 16, LAT_W = 4, ADDR_W = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_en = 0, cfg_by_ops = 0;
    logic [CNT_W-1:0] cfg_interval = '0;
    logic disp_vld = 0, cmpl_vld = 0, ret_vld = 0;
    logic [ID_W-1:0] disp_id = '0, cmpl_id = '0, ret_id = '0;
    logic ret_branch = 0, ret_taken = 0, ret_mispred = 0, ret_return = 0;
    logic [ADDR_W-1:0] ret_target = '0;
    logic flush = 0, rec_clr = 0;
    logic irq, rec_valid, rec_branch, rec_taken, rec_mispred, rec_return;
    logic [ID_W-1:0] rec_id;
    logic [LAT_W-1:0] rec_tag_lat, rec_cmpl_lat;
    logic [ADDR_W-1:0] rec_target;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    op_tag_sampler #(.ID_W(ID_W), .CNT_W(CNT_W), .LAT_W(LAT_W), .ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_by_ops(cfg_by_ops),
        .cfg_interval(cfg_interval), .disp_vld(disp_vld), .disp_id(disp_id),
        .cmpl_vld(cmpl_vld), .cmpl_id(cmpl_id), .ret_vld(ret_vld), .ret_id(ret_id),
        .ret_branch(ret_branch), .ret_taken(ret_taken), .ret_mispred(ret_mispred),
        .ret_return(ret_return), .ret_target(ret_target), .flush(flush),
        .rec_clr(rec_clr), .irq(irq), .rec_valid(rec_valid), .rec_id(rec_id),
        .rec_tag_lat(rec_tag_lat), .rec_cmpl_lat(rec_cmpl_lat),
        .rec_branch(rec_branch), .rec_taken(rec_taken), .rec_mispred(rec_mispred),
        .rec_return(rec_return), .rec_target(rec_target)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // one clock edge: inputs set before the call are sampled, outputs read after
    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic quiet();
        disp_vld = 0; cmpl_vld = 0; ret_vld = 0; flush = 0; rec_clr = 0;
        ret_branch = 0; ret_taken = 0; ret_mispred = 0; ret_return = 0; ret_target = '0;
    endtask

    task automatic dispatch(input logic [ID_W-1:0] id);
        disp_vld = 1; disp_id = id; cyc(); disp_vld = 0;
    endtask

    task automatic retire(input logic [ID_W-1:0] id);
        ret_vld = 1; ret_id = id; cyc(); ret_vld = 0;
    endtask

    task automatic release_rec();
        cfg_en = 0; rec_clr = 1; cyc(); rec_clr = 0; cyc();
    endtask

    task automatic t_reset();
        chk("R13 irq after reset", irq, 0);
        chk("R13 rec_valid after reset", rec_valid, 0);
    endtask

    // cycle mode, continuous dispatch: 5th counted edge carries id 4
    task automatic t_cycle_stream();
        cfg_by_ops = 0; cfg_interval = 5; cfg_en = 1;
        for (int k = 0; k < 8; k++) begin
            disp_vld = 1; disp_id = ID_W'(k); cyc();
        end
        disp_vld = 0;
        retire(4);
        chk("R1 R3 cycle-mode tagged id", rec_id, 4);
        chk("R4 cycle-mode tag latency", rec_tag_lat, 4);
        chk("R7 irq after retire", irq, 1);
        release_rec();
    endtask

    // same sparse pattern in both modes; interval 3
    task automatic t_pattern(input logic by_ops, input int exp_id, input int exp_lat);
        cfg_by_ops = by_ops; cfg_interval = 3; cfg_en = 1;
        for (int e = 0; e < 9; e++) begin
            disp_vld = (e == 0 || e == 3 || e == 5 || e == 8);
            disp_id  = (e == 0) ? 30 : (e == 3) ? 31 : (e == 5) ? 32 : 33;
            cyc();
        end
        disp_vld = 0;
        retire(ID_W'(exp_id));
        chk(by_ops ? "R2 op-mode tagged id" : "R3 cycle-mode late tag id", rec_id, exp_id);
        chk(by_ops ? "R1 op-mode tag latency" : "R1 cycle-mode tag latency", rec_tag_lat, exp_lat);
        release_rec();
    endtask

    task automatic t_latency();
        cfg_by_ops = 1; cfg_interval = 1; cfg_en = 1;
        dispatch(5);
        dispatch(6);                      // tag edge T
        cmpl_vld = 1; cmpl_id = 9; cyc(); cmpl_vld = 0;          // T+1 foreign
        ret_vld = 1; ret_id = 9; cyc(); ret_vld = 0;             // T+2 foreign
        chk("R9 foreign retire ignored", rec_valid, 0);
        chk("R9 foreign retire no irq", irq, 0);
        cmpl_vld = 1; cmpl_id = 6; cyc(); cmpl_vld = 0;          // T+3
        cyc(); cyc(); cyc();                                     // T+4..T+6
        ret_branch = 1; ret_taken = 1; ret_mispred = 0; ret_return = 1;
        ret_target = 32'hCAFE_0040;
        retire(6);                                               // T+7
        quiet();
        chk("R4 tag latency", rec_tag_lat, 7);
        chk("R5 completion latency", rec_cmpl_lat, 4);
        chk("R6 id", rec_id, 6);
        chk("R6 flags br/tk/mp/rt", {rec_branch, rec_taken, rec_mispred, rec_return}, 4'b1101);
        chk("R6 target", rec_target, 32'hCAFE_0040);
        chk("R7 irq high", irq, 1);
        chk("R7 rec_valid with irq", rec_valid, 1);
        cyc();
        chk("R7 irq one cycle", irq, 0);
        chk("R7 record stays", rec_valid, 1);
        release_rec();
    endtask

    task automatic t_busy_and_clear();
        cfg_by_ops = 1; cfg_interval = 1; cfg_en = 1;
        dispatch(20);
        dispatch(21);                     // tagged
        for (int k = 0; k < 3; k++) dispatch(ID_W'(22 + k));
        retire(21);
        chk("R8 tag not moved by later dispatches", rec_id, 21);
        chk("R5 no completion gives zero", rec_cmpl_lat, 0);
        for (int k = 0; k < 4; k++) begin
            dispatch(ID_W'(40 + k));
            chk("R8 no irq while held", irq, 0);
        end
        retire(22);
        chk("R8 record unchanged while held", rec_id, 21);
        rec_clr = 1; cyc(); rec_clr = 0;
        chk("R12 clear drops valid", rec_valid, 0);
        dispatch(50);
        dispatch(51);
        retire(51);
        chk("R12 new sample after clear", rec_id, 51);
        release_rec();
    endtask

    task automatic t_flush();
        cfg_by_ops = 1; cfg_interval = 1; cfg_en = 1;
        dispatch(10);
        dispatch(11);
        flush = 1; cyc(); flush = 0;
        retire(11);
        chk("R10 flushed tag no irq", irq, 0);
        chk("R10 flushed tag no record", rec_valid, 0);
        dispatch(12);
        dispatch(13);
        retire(13);
        chk("R10 counting restarts after flush", rec_id, 13);
        release_rec();
    endtask

    task automatic t_saturate();
        cfg_by_ops = 1; cfg_interval = 1; cfg_en = 1;
        dispatch(3);
        dispatch(4);                      // T
        cyc();                            // T+1
        cmpl_vld = 1; cmpl_id = 4; cyc(); cmpl_vld = 0;          // T+2
        for (int k = 0; k < 22; k++) cyc();                      // T+3..T+24
        retire(4);                                               // T+25
        chk("R11 tag latency saturates", rec_tag_lat, 15);
        chk("R11 completion latency saturates", rec_cmpl_lat, 15);
        release_rec();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        quiet();
        cyc(); cyc();
        rst_n = 1;
        cyc();
        t_reset();
        t_cycle_stream();
        t_pattern(1'b1, 33, 1);
        t_pattern(1'b0, 31, 6);
        t_latency();
        t_busy_and_clear();
        t_flush();
        t_saturate();
        finished = 1;
        summary();
        $finish;
    end
endmodule